// File: doc/BRIEF.md
# Dual DAC Serial Load Interface

This block is the digital front end of a two-channel 12-bit converter. A host frames each 16-bit word by pulling a frame-select line low, then presents one data bit per serial clock. The block samples each bit on the falling serial-clock edge. Every input is first brought into a fast system clock domain, and the edges are found there. When a word is complete, the channel-select bit routes its 12-bit code into the staging register of channel A or channel B.

The staging registers move to the held output codes in one of two ways. A falling edge on the load strobe moves both channels at the same instant. Alternatively, the strobe can be held low, and then both channels move at the end of every completed word. A clear input forces every register to zero. A format input chooses how the held codes are also presented in offset-binary form, for the downstream converter.

The framing logic is a three-state machine:
- **ST_IDLE** means no frame is open.
- **ST_SHIFT** collects bits.
- **ST_HOLD** means a full word has arrived and further clock edges are ignored.

It has four transitions:
- **start**: IDLE→SHIFT when the frame-select line goes low. The bit counter and the shift register are reset.
- **abort**: SHIFT→IDLE when the frame-select line rises before the word is complete. The partial word is dropped.
- **complete**: SHIFT→HOLD on the 16th falling edge.
- **release**: HOLD→IDLE when the frame-select line rises.

Top module: `dual_dac_serial_if`

## Requirements
- R1: After reset, both held codes and both offset-binary outputs are 0.
- R2: A word is 16 bits, shifted in MSB first. Word bit 12 selects the channel (0 = A, 1 = B) and bits 11..0 are the code. Bits 15..13 have no effect on the result.
- R3: While the load strobe is high, completed words change neither held code. A falling edge on the load strobe copies both staging registers into both held codes at the same time.
- R4: While the load strobe is held low, both held codes update on the 16th falling serial-clock edge of each word.
- R5: Falling serial-clock edges while the frame-select line is high are ignored, and they do not disturb the bit count of the next word.
- R6: Falling edges after the 16th are ignored until a new frame begins.
- R7: A word cut short, because the frame-select line rises before the 16th edge, changes neither staging register.
- R8: While the clear input is low, both staging registers and both held codes are 0, and completed words are not taken.
- R9: With format = 1, each offset-binary output is its held code with bit 11 inverted. With format = 0, it equals the held code. After a clear it therefore reads 0x800 with format = 1 and 0x000 with format = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock; bits are taken on its falling edge |
| sdin | input | 1 | Serial data |
| ldac_n | input | 1 | Load strobe; a falling edge loads, held low selects auto update |
| clr_n | input | 1 | Clear, active low |
| fmt_twos | input | 1 | 1 = twos-complement codes, 0 = binary codes |
| code_a | output | 12 | Held code of channel A |
| code_b | output | 12 | Held code of channel B |
| obin_a | output | 12 | Offset-binary view of channel A |
| obin_b | output | 12 | Offset-binary view of channel B |

## Verification
The assertions assume the following about the inputs:
- Every level seen by the design has passed through the two-stage synchronizer.
- Serial data is stable from before each serial-clock fall until after it, so that both the data bit and the clock edge leave the synchronizer in the same order in which they were driven.
- Pulses on the serial clock, the frame select and the load strobe each last several system clocks, so that no edge is lost.

The stimulus meets these assumptions. It changes only one input level at a time, sets data while the serial clock is high, and holds every level for at least four system clocks.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } frame_state_t;

endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
    parameter int              WIDTH   = 6,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/dac_frame_fsm.sv
module dac_frame_fsm
    import dac_if_pkg::*;
#(
    parameter  int WORD_BITS = 16,
    localparam int CNT_W     = $clog2(WORD_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_hi,
    input  logic                 sclk_fall,
    input  logic                 sdin_lvl,
    output logic                 word_done,
    output logic [WORD_BITS-1:0] word,
    output logic [CNT_W-1:0]     bit_cnt
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);

    frame_state_t         state_q, state_nx;
    logic                 start_frame;
    logic                 take_bit;
    logic [WORD_BITS-1:0] shreg_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions and per-state outputs
    always_comb begin
        state_nx    = state_q;
        start_frame = 1'b0;
        take_bit    = 1'b0;
        word_done   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!frame_hi) begin
                    state_nx    = ST_SHIFT;
                    start_frame = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (frame_hi) begin
                    state_nx = ST_IDLE;
                end else if (sclk_fall) begin
                    take_bit = 1'b1;
                    if (bit_cnt == LAST_IDX) begin
                        word_done = 1'b1;
                        state_nx  = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (frame_hi) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign word = {shreg_q[WORD_BITS-2:0], sdin_lvl};

    // Bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg_q <= '0;
        end else if (start_frame) begin
            bit_cnt <= '0;
            shreg_q <= '0;
        end else if (take_bit) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg_q <= word;
        end
    end

endmodule

// File: rtl/dac_code_regs.sv
module dac_code_regs #(
    parameter  int CODE_BITS = 12,
    parameter  int WORD_BITS = 16,
    localparam int SEL_BIT   = CODE_BITS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_lvl_n,
    input  logic                      word_done,
    input  logic [WORD_BITS-1:0]      word,
    input  logic                      xfer,
    output logic [1:0]                wr,
    output logic [1:0][CODE_BITS-1:0] code_o
);

    logic [CODE_BITS-1:0] stage_q [2];
    logic [CODE_BITS-1:0] held_q  [2];
    logic [CODE_BITS-1:0] new_code;

    assign new_code = word[CODE_BITS-1:0];

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        assign wr[ch] = word_done && clr_lvl_n && (word[SEL_BIT] == 1'(ch));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[ch] <= '0;
                held_q[ch]  <= '0;
            end else if (!clr_lvl_n) begin
                stage_q[ch] <= '0;
                held_q[ch]  <= '0;
            end else begin
                if (wr[ch]) begin
                    stage_q[ch] <= new_code;
                end
                if (xfer) begin
                    held_q[ch] <= wr[ch] ? new_code : stage_q[ch];
                end
            end
        end

        assign code_o[ch] = held_q[ch];
    end

endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if #(
    parameter  int CODE_BITS   = 12,
    parameter  int WORD_BITS   = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(WORD_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_n,
    input  logic                 sclk,
    input  logic                 sdin,
    input  logic                 ldac_n,
    input  logic                 clr_n,
    input  logic                 fmt_twos,
    output logic [CODE_BITS-1:0] code_a,
    output logic [CODE_BITS-1:0] code_b,
    output logic [CODE_BITS-1:0] obin_a,
    output logic [CODE_BITS-1:0] obin_b
);

    logic [5:0]                 raw_in, lvl;
    logic                       frame_hi, sclk_lvl, sdin_lvl, ldac_lvl_n, clr_lvl_n, fmt_lvl;
    logic                       sclk_prev, ldac_prev;
    logic                       sclk_fall, ldac_fall;
    logic                       word_done, xfer;
    logic [WORD_BITS-1:0]       word;
    logic [CNT_W-1:0]           bit_cnt;
    logic [1:0]                 wr;
    logic [1:0][CODE_BITS-1:0]  codes;
    logic [1:0][CODE_BITS-1:0]  obin;

    assign raw_in = {fmt_twos, clr_n, ldac_n, sdin, sclk, sync_n};

    dac_in_sync #(
        .WIDTH   (6),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (6'b011001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (lvl)
    );

    assign {fmt_lvl, clr_lvl_n, ldac_lvl_n, sdin_lvl, sclk_lvl, frame_hi} = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            ldac_prev <= 1'b1;
        end else begin
            sclk_prev <= sclk_lvl;
            ldac_prev <= ldac_lvl_n;
        end
    end

    assign sclk_fall = sclk_prev && !sclk_lvl;
    assign ldac_fall = ldac_prev && !ldac_lvl_n;

    dac_frame_fsm #(
        .WORD_BITS (WORD_BITS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_hi  (frame_hi),
        .sclk_fall (sclk_fall),
        .sdin_lvl  (sdin_lvl),
        .word_done (word_done),
        .word      (word),
        .bit_cnt   (bit_cnt)
    );

    // Load on strobe fall, or on each completed word while the strobe is held low
    assign xfer = ldac_fall || (word_done && !ldac_lvl_n);

    dac_code_regs #(
        .CODE_BITS (CODE_BITS),
        .WORD_BITS (WORD_BITS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_lvl_n (clr_lvl_n),
        .word_done (word_done),
        .word      (word),
        .xfer      (xfer),
        .wr        (wr),
        .code_o    (codes)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_view
        assign obin[ch] = fmt_lvl ? {~codes[ch][CODE_BITS-1], codes[ch][CODE_BITS-2:0]}
                                  : codes[ch];
    end

    assign code_a = codes[0];
    assign code_b = codes[1];
    assign obin_a = obin[0];
    assign obin_b = obin[1];

endmodule

// File: rtl/dac_if_checker.sv
module dac_if_checker #(
    parameter  int CODE_BITS = 12,
    parameter  int WORD_BITS = 16,
    localparam int CNT_W     = $clog2(WORD_BITS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr_lvl_n,
    input logic                 xfer,
    input logic [1:0]           wr,
    input logic                 word_done,
    input logic [CNT_W-1:0]     bit_cnt,
    input logic [CODE_BITS-1:0] code_a,
    input logic [CODE_BITS-1:0] code_b
);

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lvl_n |=> (code_a == '0) && (code_b == '0));

    p_hold_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && clr_lvl_n) |=> $stable(code_a));

    p_hold_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && clr_lvl_n) |=> $stable(code_b));

    p_one_channel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(WORD_BITS));

    p_done_last_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> bit_cnt == CNT_W'(WORD_BITS - 1));

endmodule

bind dual_dac_serial_if dac_if_checker #(
    .CODE_BITS (CODE_BITS),
    .WORD_BITS (WORD_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_lvl_n (clr_lvl_n),
    .xfer      (xfer),
    .wr        (wr),
    .word_done (word_done),
    .bit_cnt   (bit_cnt),
    .code_a    (code_a),
    .code_b    (code_b)
);

// File: tb/dual_dac_serial_if_tb.sv
`timescale 1ns/1ps
module dual_dac_serial_if_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic        ldac_n = 1'b1, clr_n = 1'b1, fmt_twos = 1'b0;
    logic [11:0] code_a, code_b, obin_a, obin_b;
    int          checks = 0;
    int          failures = 0;

    always #4 clk = ~clk;

    dual_dac_serial_if u_dut (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
        .ldac_n(ldac_n), .clr_n(clr_n), .fmt_twos(fmt_twos),
        .code_a(code_a), .code_b(code_b), .obin_a(obin_a), .obin_b(obin_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input int extra);
        sync_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            sdin = w[15-i];
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(4);
        end
        for (int i = 0; i < extra; i++) begin
            sdin = 1'b1;
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(4);
        end
        sync_n = 1'b1;
        tick(6);
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0;
        tick(6);
        ldac_n = 1'b1;
        tick(6);
    endtask

    task automatic t_reset();
        chk("R1 code_a", code_a, 12'h000);
        chk("R1 code_b", code_b, 12'h000);
        chk("R1 obin_a", obin_a, 12'h000);
        chk("R1 obin_b", obin_b, 12'h000);
    endtask

    task automatic t_strobe_load();
        ldac_n = 1'b1;
        tick(6);
        send(16'hAABC, 16, 0);          // upper bits 101, channel A
        chk("R3 held A before strobe", code_a, 12'h000);
        send(16'h5123, 16, 0);          // upper bits 010, channel B
        chk("R3 held B before strobe", code_b, 12'h000);
        pulse_ldac();
        chk("R2 R3 code_a after strobe", code_a, 12'hABC);
        chk("R2 R3 code_b after strobe", code_b, 12'h123);
    endtask

    task automatic t_auto_update();
        ldac_n = 1'b0;
        tick(6);
        send(16'h0456, 16, 0);
        chk("R4 auto code_a", code_a, 12'h456);
        chk("R4 auto code_b unchanged", code_b, 12'h123);
    endtask

    task automatic t_idle_edges();
        sdin = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(4);
        end
        chk("R5 idle edges code_a", code_a, 12'h456);
        chk("R5 idle edges code_b", code_b, 12'h123);
        send(16'h1321, 16, 0);
        chk("R5 next word aligned code_b", code_b, 12'h321);
    endtask

    task automatic t_extra_edges();
        send(16'h1789, 16, 4);
        chk("R6 extra edges code_b", code_b, 12'h789);
        chk("R6 extra edges code_a", code_a, 12'h456);
    endtask

    task automatic t_truncated();
        ldac_n = 1'b1;
        tick(6);
        send(16'h0FFF, 10, 0);
        chk("R7 short word code_a", code_a, 12'h456);
        pulse_ldac();
        chk("R7 staging A kept", code_a, 12'h456);
        chk("R7 staging B kept", code_b, 12'h789);
    endtask

    task automatic t_format();
        ldac_n = 1'b0;
        tick(6);
        send(16'h03A5, 16, 0);
        send(16'h1C00, 16, 0);
        fmt_twos = 1'b0;
        tick(6);
        chk("R9 binary obin_a", obin_a, 12'h3A5);
        chk("R9 binary obin_b", obin_b, 12'hC00);
        fmt_twos = 1'b1;
        tick(6);
        chk("R9 twos obin_a", obin_a, 12'hBA5);
        chk("R9 twos obin_b", obin_b, 12'h400);
        chk("R9 raw code_a kept", code_a, 12'h3A5);
    endtask

    task automatic t_clear();
        fmt_twos = 1'b1;
        clr_n = 1'b0;
        tick(6);
        chk("R8 clear code_a", code_a, 12'h000);
        chk("R8 clear code_b", code_b, 12'h000);
        chk("R9 clear twos obin_a", obin_a, 12'h800);
        chk("R9 clear twos obin_b", obin_b, 12'h800);
        fmt_twos = 1'b0;
        tick(6);
        chk("R9 clear binary obin_a", obin_a, 12'h000);
        send(16'h0777, 16, 0);
        chk("R8 word during clear", code_a, 12'h000);
        clr_n = 1'b1;
        tick(6);
        ldac_n = 1'b1;
        tick(6);
        pulse_ldac();
        chk("R8 staging A cleared", code_a, 12'h000);
        chk("R8 staging B cleared", code_b, 12'h000);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_strobe_load();
        t_auto_update();
        t_idle_edges();
        t_extra_edges();
        t_truncated();
        t_format();
        t_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired got=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule